// File: doc/BRIEF.md
# Four-Entry Sample Queue with Sticky Error Flags

This block buffers converter results on their way to a processor register port. A conversion-done strobe or a software test write places a 12-bit sample into a small circular store. A read strobe takes the oldest sample out and loads it into a held read-data register. That register keeps its value until the next successful read.

A five-bit status word reports the fill state and two error conditions. The error flags are sticky. While the overflow flag is set, no further sample is accepted. While the underflow flag is set, the read position does not move and the read data keeps its old value. A flush input returns the queue to empty and clears both flags in a single cycle. The held read value is not affected by a flush.

All inputs are sampled on the rising clock edge. The status word and the read data show the effect of an edge right after that edge.

Top module: `sample_fifo`

## Requirements
- R1: After reset, status reads 5'b00001 (empty only) and rd_data reads 0.
- R2: Status bit 0 (empty) is 1 exactly when no sample is held, and status bit 2 (full) is 1 exactly when 4 samples are held.
- R3: Status bit 1 (almost full) is 1 only when exactly 3 samples are held. It is 0 at 0, 1, 2 and 4 samples.
- R4: A read strobe on a non-empty queue loads the oldest held sample into rd_data, visible after that edge. Samples leave in the order they were written, and rd_data holds its value when no read succeeds.
- R5: A software write (sw_wr) stores sw_data exactly as a converter write (conv_wr) stores conv_data. When both strobes arrive in the same cycle, the converter sample is stored and the software sample is dropped.
- R6: A write attempt while full sets status bit 4 (overflow). The flag stays set until a flush, and every write while it is set is dropped, even after reads have freed space.
- R7: A read strobe while empty sets status bit 3 (underflow) and leaves rd_data at the last sample read. The flag stays set until a flush, and while it is set reads neither remove samples nor change rd_data.
- R8: A flush empties the queue and clears both sticky flags in one cycle, so status reads 5'b00001 after that edge. rd_data keeps its value, and a write or read in the same cycle as a flush has no effect.
- R9: A write and a read in the same cycle on a queue holding 1 to 3 samples both succeed, and the fill level is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_wr | input | 1 | Converter result strobe |
| conv_data | input | 12 | Converter result sample |
| sw_wr | input | 1 | Software dummy-sample write strobe |
| sw_data | input | 12 | Software dummy sample |
| rd | input | 1 | Read strobe, takes the oldest sample |
| flush | input | 1 | Empty the queue and clear the sticky flags |
| rd_data | output | 12 | Held value of the last sample read |
| status | output | 5 | {overflow, underflow, full, almost full, empty} |

## Verification
A wrong fill count shows up in the status bits on the very next cycle. It appears as a wrong empty, almost-full or full bit, or as an error flag raised at the wrong fill level. A wrong read or write position does not show up in the status at all. It appears only when a read returns a sample out of order, which can be several cycles after the fault. A long mixed sequence of writes, reads and flushes is therefore compared every cycle against a queue model built from the requirements. A flag that fails to stick, or a pointer that moves while frozen, appears in rd_data on the first read after that.

// File: rtl/sample_fifo_pkg.sv
package sample_fifo_pkg;
  // Packed layout: the first member is the MSB, so empty lands on bit 0.
  typedef struct packed {
    logic ovf;
    logic unf;
    logic full;
    logic afull;
    logic empty;
  } fifo_stat_t;
endpackage

// File: rtl/sample_fifo_ctrl.sv
module sample_fifo_ctrl #(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          flush,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          unf
);
  logic [AW-1:0] wptr, rptr;
  logic full, empty, push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push_req & ~full & ~ovf & ~flush;
  assign pop_ok  = pop_req & ~empty & ~unf & ~flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      if (push_req && !push_ok) ovf <= 1'b1;
      if (pop_req && !pop_ok)   unf <= 1'b1;
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      if (push_ok && !pop_ok)      count <= count + CW'(1);
      else if (pop_ok && !push_ok) count <= count - CW'(1);
    end
  end

  assign wr_en   = push_ok;
  assign wr_addr = wptr;
  assign rd_en   = pop_ok;
  assign rd_addr = rptr;

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_ovf_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (push_req && full && !flush) |=> ovf);
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (ovf && !flush) |=> (ovf && $stable(wptr)));
  assert_unf_sets_R7: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty && !flush) |=> unf);
  assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (unf && !flush) |=> (unf && $stable(rptr)));
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0 && !ovf && !unf && wptr == '0 && rptr == '0));
  assert_pushpop_level_R9: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req && !flush && !ovf && !unf && !empty && !full) |=> $stable(count));
endmodule

// File: rtl/sample_fifo_store.sv
module sample_fifo_store #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/sample_fifo_status.sv
module sample_fifo_status
  import sample_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  logic          ovf,
  input  logic          unf,
  output fifo_stat_t    stat
);
  always_comb begin
    stat.ovf   = ovf;
    stat.unf   = unf;
    stat.full  = (count == CW'(DEPTH));
    stat.afull = (count == CW'(DEPTH - 1));
    stat.empty = (count == '0);
  end

  always_comb begin
    assert_level_exclusive_R3: assert ($onehot0({stat.empty, stat.afull, stat.full}));
  end
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo
  import sample_fifo_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_wr,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_data,
  input  logic              rd,
  input  logic              flush,
  output logic [DATA_W-1:0] rd_data,
  output logic [4:0]        status
);
  logic              wr_en, rd_en, ovf, unf;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [CW-1:0]     count;
  logic [DATA_W-1:0] push_data;
  fifo_stat_t        stat;

  // The converter sample takes precedence over a same-cycle software write.
  assign push_data = conv_wr ? conv_data : sw_data;

  sample_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push_req(conv_wr | sw_wr), .pop_req(rd),
    .flush(flush), .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en),
    .rd_addr(rd_addr), .count(count), .ovf(ovf), .unf(unf)
  );

  sample_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(push_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(rd_data)
  );

  sample_fifo_status #(.DEPTH(DEPTH)) u_status (
    .count(count), .ovf(ovf), .unf(unf), .stat(stat)
  );

  assign status = stat;
endmodule

// File: tb/sample_fifo_bench.sv
module sample_fifo_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_wr = 0, sw_wr = 0, rd = 0, flush = 0;
  logic [11:0] conv_data = 0, sw_data = 0;
  logic [11:0] rd_data;
  logic [4:0]  status;

  int n_cmp = 0, n_bad = 0, cycles = 0;

  // Queue model built from the requirements.
  logic [11:0] q [4];
  int m_cnt = 0, m_rp = 0, m_wp = 0;
  logic m_ovf = 0, m_unf = 0;
  logic [11:0] m_last = 0;

  always #10 clk = ~clk;

  sample_fifo u_sample_fifo (
    .clk(clk), .rst(rst), .conv_wr(conv_wr), .conv_data(conv_data),
    .sw_wr(sw_wr), .sw_data(sw_data), .rd(rd), .flush(flush),
    .rd_data(rd_data), .status(status)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=<100000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [4:0] exp_stat();
    return {m_ovf, m_unf, m_cnt == 4, m_cnt == 3, m_cnt == 0};
  endfunction

  task automatic check(input string tag);
    n_cmp++;
    if (status !== exp_stat()) begin
      n_bad++;
      $display("FAIL %s status act=%b exp=%b", tag, status, exp_stat());
    end
    n_cmp++;
    if (rd_data !== m_last) begin
      n_bad++;
      $display("FAIL %s rd_data act=%h exp=%h", tag, rd_data, m_last);
    end
  endtask

  task automatic model(input logic c, input logic [11:0] cd, input logic s,
                       input logic [11:0] sd, input logic r, input logic f);
    logic pok, rok;
    logic [11:0] pd;
    if (f) begin
      m_cnt = 0; m_rp = 0; m_wp = 0; m_ovf = 0; m_unf = 0;
    end else begin
      pd  = c ? cd : sd;
      pok = (c | s) && m_cnt != 4 && !m_ovf;
      rok = r && m_cnt != 0 && !m_unf;
      if ((c | s) && !pok) m_ovf = 1;
      if (r && !rok) m_unf = 1;
      if (rok) begin m_last = q[m_rp]; m_rp = (m_rp + 1) % 4; end
      if (pok) begin q[m_wp] = pd; m_wp = (m_wp + 1) % 4; end
      m_cnt = m_cnt + (pok ? 1 : 0) - (rok ? 1 : 0);
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, then check.
  task automatic step(input logic c, input logic [11:0] cd, input logic s,
                      input logic [11:0] sd, input logic r, input logic f,
                      input string tag);
    conv_wr = c; conv_data = cd; sw_wr = s; sw_data = sd; rd = r; flush = f;
    @(posedge clk);
    model(c, cd, s, sd, r, f);
    @(negedge clk);
    conv_wr = 0; sw_wr = 0; rd = 0; flush = 0;
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (status !== 5'b00001 || rd_data !== 12'h000) begin
      n_bad++;
      $display("FAIL R1 act=%b/%h exp=00001/000", status, rd_data);
    end
    check("R1");

    // R2 R3: fill 1..4, checking every level
    for (int i = 0; i < 4; i++) step(1, 12'h100 + 12'(i), 0, 0, 0, 0, "R2 R3");
    // R6: write while full, then read to free space and write again
    step(1, 12'hBAD, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 0, "R4");
    step(0, 0, 1, 12'hCAF, 0, 0, "R6");
    // R4: drain in order
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, "R4");
    // R7: read while empty, then write and read with underflow set
    step(0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 1, 0, "R7");
    // ovf still set here, so flush first to test frozen read pointer
    step(0, 0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 1, 0, "R7");
    step(1, 12'h7A7, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 0, "R7");
    // R8: flush with same-cycle write and read ignored, rd_data kept
    step(1, 12'h555, 0, 0, 1, 1, "R8");
    step(0, 0, 0, 0, 1, 0, "R8");
    step(0, 0, 0, 0, 0, 1, "R8");
    // R5: software write alone, then both strobes together
    step(0, 0, 1, 12'hABC, 0, 0, "R5");
    step(1, 12'h321, 1, 12'hFED, 0, 0, "R5");
    step(0, 0, 0, 0, 1, 0, "R5");
    step(0, 0, 0, 0, 1, 0, "R5");
    // R9: simultaneous push and pop at levels 1, 2, 3
    for (int lvl = 1; lvl <= 3; lvl++) begin
      step(0, 0, 0, 0, 0, 1, "R9");
      for (int k = 0; k < lvl; k++) step(1, 12'h200 + 12'(k), 0, 0, 0, 0, "R9");
      step(1, 12'h2F0 + 12'(lvl), 0, 0, 1, 0, "R9");
      step(1, 12'h2E0 + 12'(lvl), 0, 0, 1, 0, "R9");
    end
    // Mixed sweep of all strobe combinations against the model
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] sel;
      sel = 5'($urandom_range(0, 31));
      step(sel[0], 12'($urandom), sel[1], 12'($urandom), sel[2],
           (sel[4:3] == 2'b11) && ($urandom_range(0, 3) == 0), "R4 R6 R7 R9");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule